// File: doc/BRIEF.md
# Fixed-Priority Interrupt Resolver with Acknowledge

This block is the arbitration core of an eight-input interrupt controller. Each request line is edge-captured into a pending-request register. The block picks one pending, unmasked level, raises a single interrupt output towards the processor, and holds it there. When the processor acknowledges, the block returns a vector built from a software-supplied base and the winning level, and moves that level into the in-service register.

Level 0 has the highest priority and the highest level number the lowest. In the default nested mode, a level in service blocks itself and every lower-priority level until an end-of-interrupt command retires it. A special-mask mode lets any level that is not itself in service compete. An auto-EOI mode skips setting the in-service bit on acknowledge. End-of-interrupt commands come either as a non-specific pulse, which retires the highest-priority level in service, or as a specific pulse with a level number.

Top module: `intr_resolver`

## Requirements
- R1: While rst_n is low at a clock edge, int_out, irr_out, isr_out and vector are all cleared to zero.
- R2: A 0-to-1 change on req_lines[i] sets irr_out[i] at the next edge. When a level wins arbitration, int_out rises and that level's irr_out bit is cleared at the edge after the one that captured the request.
- R3: Only levels with irr_out set and mask clear (mask bit 1 = masked) can win. A masked request stays pending in irr_out and does not raise int_out.
- R4: A 1-to-0 change on req_lines[i] clears irr_out[i] at the next edge only if mask[i] is 1. An unmasked pending bit is kept.
- R5: With spec_mask_mode = 0 and isr_out nonzero, only levels numbered strictly below the lowest-numbered set isr_out bit may win. With isr_out[0] set, nothing wins. Among the eligible levels the lowest number wins.
- R6: Once int_out is high, it stays high and no new level is chosen until ack is sampled high.
- R7: ack sampled high while int_out is high drops int_out at that edge, loads vector with vec_base OR the winning level number, and sets that level's isr_out bit.
- R8: With auto_eoi = 1 at the acknowledge edge, isr_out is left unchanged by the acknowledge. The vector is still returned.
- R9: eoi_ns clears the lowest-numbered set isr_out bit, and has no effect when isr_out is zero. eoi_sp clears isr_out[eoi_lvl]. The next arbitration, one edge later, sees the updated isr_out.
- R10: With spec_mask_mode = 1, every level whose isr_out bit is clear may compete, including levels of lower priority than those in service. Levels in service are excluded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lines | input | 8 | Interrupt request lines, edge-captured |
| mask | input | 8 | Per-level mask, 1 = masked |
| vec_base | input | 8 | Vector base, ORed with the level number |
| auto_eoi | input | 1 | 1 = acknowledge does not set the in-service bit |
| spec_mask_mode | input | 1 | 1 = special-mask arbitration |
| eoi_ns | input | 1 | Non-specific end-of-interrupt pulse |
| eoi_sp | input | 1 | Specific end-of-interrupt pulse |
| eoi_lvl | input | 3 | Level retired by eoi_sp |
| ack | input | 1 | Processor acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last acknowledged level |
| irr_out | output | 8 | Pending-request register |
| isr_out | output | 8 | In-service register |

## Verification
A corrupted in-service register shows up as the wrong nesting behaviour. A lower-priority request is either let through, or held back after its blocker was retired, and this is visible on int_out one edge after the faulty state. A wrong recorded level or base merge appears in vector at the edge after the acknowledge. A lost or stale pending bit appears in irr_out at once and in int_out one edge later. The bench therefore compares vector after every acknowledge and checks int_out, irr_out and isr_out after each edge-captured request, mask change and end-of-interrupt command.

// File: rtl/intr_res_pkg.sv
// Shared constants and types for the interrupt resolver.
// Assumes nothing beyond the defaults being overridden consistently.
package intr_res_pkg;
    localparam int unsigned DEF_LEVELS = 8;
    localparam int unsigned DEF_VEC_W  = 8;

    // Arbitration window selection
    typedef enum logic {
        ARB_NESTED  = 1'b0,
        ARB_SPECIAL = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/prio_pick.sv
// Finds the lowest-numbered set bit of a vector (highest priority).
// Returns it one-hot, as an index, and a non-empty flag. Purely combinational.
module prio_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    // Prefix chain: a bit wins only if no lower-numbered bit is set
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign onehot[i]  = vec[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | vec[i];
    end

    assign any = seen[N];

    // Encode the one-hot winner into an index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/irr_capture.sv
// Edge-captures request lines into the pending-request register.
// A rising line sets its bit. A falling line clears it only when masked.
// A grant clears the granted bit. Assumes grant_clr is one-hot or zero.
module irr_capture #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_lines,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] grant_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] req_q;
    logic [N-1:0] rise;
    logic [N-1:0] fall_masked;

    // Edge classification of the request lines
    assign rise        = req_lines & ~req_q;
    assign fall_masked = ~req_lines & req_q & mask;

    // Previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_lines;
    end

    // Pending-request register update
    always_ff @(posedge clk) begin
        if (!rst_n) irr <= '0;
        else        irr <= (irr & ~grant_clr & ~fall_masked) | rise;
    end
endmodule

// File: rtl/service_ctl.sv
// Holds the interrupt output, the recorded winner, the in-service register
// and the returned vector. Grants only while no interrupt is outstanding.
// Assumes cand_any/cand_idx come from arbitration on the current registers.
module service_ctl #(
    parameter int unsigned N     = 8,
    parameter int unsigned IW    = $clog2(N),
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_any,
    input  logic [N-1:0]     cand_onehot,
    input  logic [IW-1:0]    cand_idx,
    input  logic [N-1:0]     isr_low_onehot,
    input  logic             ack,
    input  logic             auto_eoi,
    input  logic             eoi_ns,
    input  logic             eoi_sp,
    input  logic [IW-1:0]    eoi_lvl,
    input  logic [VEC_W-1:0] vec_base,
    output logic             int_q,
    output logic [N-1:0]     grant_clr,
    output logic [N-1:0]     isr,
    output logic [VEC_W-1:0] vector
);
    logic          grant;
    logic          take_ack;
    logic [IW-1:0] lvl_q;
    logic [N-1:0]  eoi_clr;
    logic [N-1:0]  ack_set;

    // Grant decision and acknowledge qualification
    assign grant     = cand_any & ~int_q;
    assign take_ack  = ack & int_q;
    assign grant_clr = grant ? cand_onehot : '0;

    // In-service bits retired and added this cycle
    always_comb begin
        eoi_clr = '0;
        if (eoi_ns) eoi_clr = eoi_clr | isr_low_onehot;
        if (eoi_sp) eoi_clr = eoi_clr | (N'(1) << eoi_lvl);
        ack_set = (take_ack && !auto_eoi) ? (N'(1) << lvl_q) : '0;
    end

    // Interrupt output and recorded winning level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= 1'b0;
            lvl_q <= '0;
        end else if (grant) begin
            int_q <= 1'b1;
            lvl_q <= cand_idx;
        end else if (take_ack) begin
            int_q <= 1'b0;
        end
    end

    // In-service register
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eoi_clr) | ack_set;
    end

    // Vector returned on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)        vector <= '0;
        else if (take_ack) vector <= vec_base | VEC_W'(lvl_q);
    end
endmodule

// File: rtl/intr_resolver.sv
// Top of the fixed-priority interrupt resolver. Builds the arbitration window
// from the in-service register and mode, picks the highest-priority candidate,
// and hands it to the service controller. One clock from any state change
// to the resulting interrupt output.
module intr_resolver
    import intr_res_pkg::*;
#(
    parameter int unsigned N_LVL = DEF_LEVELS,
    parameter int unsigned VEC_W = DEF_VEC_W,
    localparam int unsigned IW   = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] req_lines,
    input  logic [N_LVL-1:0] mask,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             auto_eoi,
    input  logic             spec_mask_mode,
    input  logic             eoi_ns,
    input  logic             eoi_sp,
    input  logic [IW-1:0]    eoi_lvl,
    input  logic             ack,
    output logic             int_out,
    output logic [VEC_W-1:0] vector,
    output logic [N_LVL-1:0] irr_out,
    output logic [N_LVL-1:0] isr_out
);
    logic [N_LVL-1:0] irr;
    logic [N_LVL-1:0] isr;
    logic [N_LVL-1:0] grant_clr;
    logic [N_LVL-1:0] isr_low_onehot;
    logic [IW-1:0]    isr_low_idx;
    logic             isr_any;
    logic [N_LVL-1:0] window;
    logic [N_LVL-1:0] cand;
    logic [N_LVL-1:0] cand_onehot;
    logic [IW-1:0]    cand_idx;
    logic             cand_any;
    arb_mode_e        mode;

    assign mode = spec_mask_mode ? ARB_SPECIAL : ARB_NESTED;

    irr_capture #(.N(N_LVL)) u_irr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_lines (req_lines),
        .mask      (mask),
        .grant_clr (grant_clr),
        .irr       (irr)
    );

    // Highest-priority level currently in service
    prio_pick #(.N(N_LVL), .IW(IW)) u_isr_pick (
        .vec    (isr),
        .onehot (isr_low_onehot),
        .idx    (isr_low_idx),
        .any    (isr_any)
    );

    // Levels allowed to compete under the current mode
    always_comb begin
        if (mode == ARB_SPECIAL) window = ~isr;
        else if (isr_any)        window = isr_low_onehot - N_LVL'(1);
        else                     window = '1;
        cand = irr & ~mask & window;
    end

    // Winner among eligible, unmasked pending levels
    prio_pick #(.N(N_LVL), .IW(IW)) u_cand_pick (
        .vec    (cand),
        .onehot (cand_onehot),
        .idx    (cand_idx),
        .any    (cand_any)
    );

    service_ctl #(.N(N_LVL), .IW(IW), .VEC_W(VEC_W)) u_svc (
        .clk            (clk),
        .rst_n          (rst_n),
        .cand_any       (cand_any),
        .cand_onehot    (cand_onehot),
        .cand_idx       (cand_idx),
        .isr_low_onehot (isr_low_onehot),
        .ack            (ack),
        .auto_eoi       (auto_eoi),
        .eoi_ns         (eoi_ns),
        .eoi_sp         (eoi_sp),
        .eoi_lvl        (eoi_lvl),
        .vec_base       (vec_base),
        .int_q          (int_out),
        .grant_clr      (grant_clr),
        .isr            (isr),
        .vector         (vector)
    );

    assign irr_out = irr;
    assign isr_out = isr;

    // Index of the lowest in-service bit is not needed at the top
    logic unused_ok;
    assign unused_ok = ^isr_low_idx;
endmodule

// File: rtl/intr_resolver_chk.sv
// Port-level temporal checks for the interrupt resolver, attached by bind.
module intr_resolver_chk #(
    parameter int unsigned N_LVL = 8,
    parameter int unsigned IW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             auto_eoi,
    input logic             spec_mask_mode,
    input logic             eoi_ns,
    input logic             eoi_sp,
    input logic [IW-1:0]    eoi_lvl,
    input logic [N_LVL-1:0] mask,
    input logic             int_out,
    input logic [N_LVL-1:0] irr_out,
    input logic [N_LVL-1:0] isr_out
);
    // R6
    int_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && !ack) |=> int_out);

    // R7
    ack_drops_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && ack) |=> !int_out);

    // R3
    rise_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_out) |-> (($past(irr_out) & ~$past(mask)) != '0));

    // R5
    lvl0_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(isr_out[0]) && !$past(spec_mask_mode)) |-> !$rose(int_out));

    // R8
    auto_eoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && ack && auto_eoi && !eoi_ns && !eoi_sp) |=> (isr_out == $past(isr_out)));

    // R9
    spec_eoi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_sp && !ack) |=> !isr_out[$past(eoi_lvl)]);
endmodule

bind intr_resolver intr_resolver_chk #(.N_LVL(N_LVL), .IW(IW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ack            (ack),
    .auto_eoi       (auto_eoi),
    .spec_mask_mode (spec_mask_mode),
    .eoi_ns         (eoi_ns),
    .eoi_sp         (eoi_sp),
    .eoi_lvl        (eoi_lvl),
    .mask           (mask),
    .int_out        (int_out),
    .irr_out        (irr_out),
    .isr_out        (isr_out)
);

// File: tb/intr_resolver_tb.sv
// Scoreboard bench: acknowledges push expected vectors, a monitor compares.
module intr_resolver_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_lines = '0;
    logic [7:0] mask = '0;
    logic [7:0] vec_base = 8'h20;
    logic       auto_eoi = 1'b0;
    logic       spec_mask_mode = 1'b0;
    logic       eoi_ns = 1'b0;
    logic       eoi_sp = 1'b0;
    logic [2:0] eoi_lvl = '0;
    logic       ack = 1'b0;
    logic       int_out;
    logic [7:0] vector;
    logic [7:0] irr_out;
    logic [7:0] isr_out;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { string tag; logic [7:0] exp; } exp_item_t;
    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    intr_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_lines(req_lines), .mask(mask),
        .vec_base(vec_base), .auto_eoi(auto_eoi), .spec_mask_mode(spec_mask_mode),
        .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_lvl(eoi_lvl), .ack(ack),
        .int_out(int_out), .vector(vector), .irr_out(irr_out), .isr_out(isr_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Driver: acknowledge and push the expected vector
    task automatic do_ack(input logic [7:0] exp, input string tag);
        sb_q.push_back('{tag, exp});
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic pulse_ns();
        eoi_ns = 1'b1; step(); eoi_ns = 1'b0;
    endtask

    task automatic pulse_sp(input logic [2:0] l);
        eoi_lvl = l; eoi_sp = 1'b1; step(); eoi_sp = 1'b0;
    endtask

    // Monitor: compare vector and int_out after every acknowledge edge
    always @(posedge clk) begin
        if (rst_n && ack) begin
            #5;
            if (sb_q.size() == 0) begin
                chk("R7 unexpected ack", 1, 0);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                chk({it.tag, " vector"}, vector, it.exp);
                chk({it.tag, " int low"}, int_out, 0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        // R1 reset state
        chk("R1 int", int_out, 0);
        chk("R1 irr", irr_out, 0);
        chk("R1 isr", isr_out, 0);
        chk("R1 vector", vector, 0);
        rst_n = 1'b1;
        step();

        // R2 single request
        req_lines[3] = 1'b1; step(); step();
        chk("R2 int", int_out, 1);
        chk("R2 irr cleared", irr_out, 0);
        do_ack(8'h23, "R7 level3");
        chk("R7 isr", isr_out, 8'h08);

        // R5 nesting
        req_lines[5] = 1'b1; step(); step();
        chk("R5 lower blocked", int_out, 0);
        chk("R2 irr pending", irr_out, 8'h20);
        req_lines[1] = 1'b1; step(); step();
        chk("R5 higher wins", int_out, 1);
        do_ack(8'h21, "R5 level1");
        chk("R5 isr nested", isr_out, 8'h0A);

        // R9 EOI commands
        pulse_ns();
        chk("R9 ns clears lowest", isr_out, 8'h08);
        step();
        chk("R5 still blocked", int_out, 0);
        pulse_sp(3'd3);
        chk("R9 sp clears", isr_out, 8'h00);
        step();
        chk("R9 rearbitrate", int_out, 1);
        do_ack(8'h25, "R9 level5");
        pulse_sp(3'd5);

        // R3 / R4 masking
        mask = 8'h04;
        req_lines[2] = 1'b1; step(); step();
        chk("R3 masked pending", irr_out, 8'h04);
        chk("R3 masked no int", int_out, 0);
        req_lines[2] = 1'b0; step();
        chk("R4 masked fall clears", irr_out, 8'h00);
        mask = 8'h00;

        // R6 hold while outstanding
        req_lines[4] = 1'b1; step(); step();
        chk("R6 int level4", int_out, 1);
        req_lines[6] = 1'b1; req_lines[0] = 1'b1; step(); step();
        chk("R6 int held", int_out, 1);
        chk("R6 irr pending", irr_out, 8'h41);
        req_lines[6] = 1'b0; step();
        chk("R4 unmasked fall kept", irr_out, 8'h41);
        do_ack(8'h24, "R6 old winner");
        step();
        chk("R5 level0 wins", int_out, 1);
        do_ack(8'h20, "R5 level0");
        step(); step();
        chk("R5 level0 blocks all", int_out, 0);
        pulse_ns(); step();
        chk("R5 level4 blocks 6", int_out, 0);
        pulse_ns(); step();
        chk("R9 level6 released", int_out, 1);
        do_ack(8'h26, "R9 level6");
        pulse_ns();
        req_lines[0] = 1'b0; req_lines[4] = 1'b0; step();

        // R10 special mask mode
        req_lines[2] = 1'b1; step(); step();
        do_ack(8'h22, "R10 setup");
        spec_mask_mode = 1'b1;
        req_lines[5] = 1'b0; step();
        req_lines[5] = 1'b1; step(); step();
        chk("R10 lower level allowed", int_out, 1);
        do_ack(8'h25, "R10 level5");
        chk("R10 isr", isr_out, 8'h24);
        req_lines[2] = 1'b0; step();
        req_lines[2] = 1'b1; step(); step();
        chk("R10 in-service excluded", int_out, 0);
        chk("R10 irr", irr_out, 8'h04);
        pulse_sp(3'd2); step();
        chk("R10 after retire", int_out, 1);
        do_ack(8'h22, "R10 level2");
        spec_mask_mode = 1'b0;
        pulse_ns(); pulse_ns();
        chk("R9 all retired", isr_out, 8'h00);

        // R8 auto-EOI with a new base
        auto_eoi = 1'b1; vec_base = 8'h78;
        req_lines[7] = 1'b1; step(); step();
        do_ack(8'h7F, "R8 level7");
        chk("R8 isr untouched", isr_out, 8'h00);
        pulse_ns();
        chk("R9 ns on empty", isr_out, 8'h00);
        step();

        chk("R7 scoreboard drained", sb_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule